// File: doc/BRIEF.md
# Runtime-Selectable Signal Sample Packer

This block takes a snapshot of a chip's internal observation signals each time a sample strobe arrives. It turns the snapshot into a short burst of 64-bit words on a valid/ready stream toward a host-side FIFO. The first word of every burst always holds the low 24 bits of a free-running timestamp and 19 digital bits. Each of the 19 digital bits is taken from a wide digital bank through a host-written index table.

After the first word come zero to four further words. They hold only the 16-bit analogue channels that the host has enabled in a channel mask. The channels are packed four per word, with the lowest enabled index first. The packing hardware is fixed, and the host picks what is visible by rewriting the mask and the index table. Stream bandwidth therefore follows the number of signals being watched, and every signal can still be reached.

All selection inputs are sampled at the strobe, so a change never disturbs a burst that is already in flight. A strobe that arrives while the previous burst still has words left to send is discarded. The discard raises a sticky overflow flag, which the host clears.

Top module: `sample_packer`

## Requirements
- R1: While reset is applied and on the first cycle after it, `m_valid_o` and `ovf_o` are 0.
- R2: The first word of a burst has `ts_i[23:0]` in bits [23:0] and the 19 selected digital bits in bits [42:24]. Bits [63:43] are zero. The timestamp is the value on `ts_i` in the strobe cycle.
- R3: Digital bit k of the first word (word bit 24+k) equals `dig_i[cfg_dig_idx_i[k*IDX_W +: IDX_W]]`, with IDX_W = clog2(NUM_DIG), which is 5 by default.
- R4: A burst has 1 + min(4, ceil(n/4)) words, where n is the number of set bits in `cfg_ana_mask_i` in the strobe cycle.
- R5: The enabled channels are packed in ascending index order. The j-th of them goes to word 1 + j/4, bits [16*(j%4)+15 : 16*(j%4)], and lanes that no channel fills are zero.
- R6: When more than 16 channels are enabled, only the 16 lowest-indexed of them are sent.
- R7: Changes to the mask, the index table, `dig_i`, `ana_i` or `ts_i` after the strobe cycle do not change the burst that the strobe started.
- R8: `m_first_o` is 1 on the first word of each burst and 0 on every other word.
- R9: While `m_valid_o` is 1 and `m_ready_i` is 0, `m_valid_o`, `m_data_o` and `m_first_o` hold their values.
- R10: A strobe that arrives while a burst has words left to send, other than in the cycle its last word is accepted, is dropped: it produces no words and sets `ovf_o` on the next cycle.
- R11: `ovf_o` stays 1 until `ovf_clr_i` is pulsed. When a clear and a drop fall in the same cycle, the flag ends up 1.
- R12: A strobe in the cycle the last word of a burst is accepted starts the next burst at once: the following cycle shows its first word, and `ovf_o` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 1 | Sample strobe, one cycle per sample |
| ts_i | input | TS_IN_W (32) | Free-running timestamp |
| dig_i | input | NUM_DIG (32) | Digital observation bank |
| ana_i | input | NUM_ANA*16 (320) | Analogue channels, channel i at bits [16i+15:16i] |
| cfg_ana_mask_i | input | NUM_ANA (20) | Host channel enable mask |
| cfg_dig_idx_i | input | 19*IDX_W (95) | Host digital index table, entry k at bits [k*IDX_W +: IDX_W] |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| m_ready_i | input | 1 | Stream ready from the FIFO |
| m_valid_o | output | 1 | Stream word valid |
| m_data_o | output | 64 | Stream word |
| m_first_o | output | 1 | Marks the first word of a burst |
| ovf_o | output | 1 | Sticky dropped-sample flag |

## Verification
The hardest case to reach from the ports is a strobe that lands exactly in the cycle the last word of a burst is accepted. One cycle earlier the strobe is dropped, and one cycle later it is an ordinary start. The bench gets there by chaining bursts: while it reads the final expected word with ready high, it arms the next sample in the same cycle, so the strobe lines up with that last handshake. Drops are forced by holding ready low across a second strobe, once with a clear pulse in the same cycle. A sweep of single-bit, random, empty and over-full channel masks covers every burst length and the truncation to 16 channels.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int WORD_W     = 64;
    localparam int TS_W       = 24;
    localparam int DSEL_N     = 19;
    localparam int LANE_W     = 16;
    localparam int LANES      = WORD_W / LANE_W;
    localparam int MAX_AWORDS = 4;
    localparam int MAX_WORDS  = MAX_AWORDS + 1;
    localparam int MAX_ACH    = MAX_AWORDS * LANES;
    localparam int CNT_W      = $clog2(MAX_WORDS + 1);
    localparam int PAD_W      = WORD_W - TS_W - DSEL_N;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  wcnt_t;

    // Layout of the leading word; the last member sits at the LSB end.
    typedef struct packed {
        logic [PAD_W-1:0]  pad;
        logic [DSEL_N-1:0] dig;
        logic [TS_W-1:0]   ts;
    } head_t;

    typedef enum logic [0:0] {TX_IDLE, TX_SEND} tx_state_e;

    function automatic wcnt_t burst_len(input int unsigned nsel);
        int unsigned aw;
        aw = (nsel + LANES - 1) / LANES;
        if (aw > MAX_AWORDS) aw = MAX_AWORDS;
        return wcnt_t'(aw + 1);
    endfunction
endpackage

// File: rtl/sp_dig_select.sv
module sp_dig_select
    import sp_pkg::*;
#(
    parameter int NUM_DIG = 32,
    localparam int IDX_W = $clog2(NUM_DIG)
) (
    input  logic [NUM_DIG-1:0]      dig_i,
    input  logic [DSEL_N*IDX_W-1:0] idx_i,
    output logic [DSEL_N-1:0]       bits_o
);
    for (genvar k = 0; k < DSEL_N; k++) begin : g_bit
        logic [IDX_W-1:0] sel;
        assign sel = idx_i[k*IDX_W +: IDX_W];
        // Indices beyond the bank read as zero.
        assign bits_o[k] = (int'(sel) < NUM_DIG) ? dig_i[sel] : 1'b0;
    end
endmodule

// File: rtl/sp_ana_compact.sv
module sp_ana_compact
    import sp_pkg::*;
#(
    parameter int NUM_ANA = 20
) (
    input  logic [NUM_ANA*LANE_W-1:0] ana_i,
    input  logic [NUM_ANA-1:0]        mask_i,
    output logic [MAX_ACH*LANE_W-1:0] lanes_o,
    output wcnt_t                     nwords_o
);
    int unsigned fill;

    // Enabled channels slide down to the lowest free lane; the rest stay zero.
    always_comb begin
        lanes_o = '0;
        fill    = 0;
        for (int i = 0; i < NUM_ANA; i++) begin
            if (mask_i[i] && fill < MAX_ACH) begin
                lanes_o[fill*LANE_W +: LANE_W] = ana_i[i*LANE_W +: LANE_W];
                fill = fill + 1;
            end
        end
        nwords_o = burst_len(fill);
    end
endmodule

// File: rtl/sp_burst_tx.sv
module sp_burst_tx
    import sp_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load_i,
    input  logic [MAX_WORDS*WORD_W-1:0] words_i,
    input  wcnt_t                       nwords_i,
    input  logic                        ovf_clr_i,
    input  logic                        m_ready_i,
    output logic                        m_valid_o,
    output word_t                       m_data_o,
    output logic                        m_first_o,
    output logic                        ovf_o
);
    tx_state_e state_q;
    word_t     hold_q [MAX_WORDS];
    wcnt_t     pos_q;
    wcnt_t     len_q;
    logic      ovf_q;

    logic fire, at_end, room, accept, drop;

    assign fire   = (state_q == TX_SEND) && m_ready_i;
    assign at_end = (pos_q == len_q - wcnt_t'(1));
    assign room   = (state_q == TX_IDLE) || (fire && at_end);
    assign accept = load_i && room;
    assign drop   = load_i && !room;

    always_ff @(posedge clk) begin
        if (accept) begin
            for (int w = 0; w < MAX_WORDS; w++)
                hold_q[w] <= words_i[w*WORD_W +: WORD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
            pos_q   <= '0;
            len_q   <= wcnt_t'(1);
            ovf_q   <= 1'b0;
        end else begin
            if (accept) begin
                state_q <= TX_SEND;
                pos_q   <= '0;
                len_q   <= nwords_i;
            end else if (fire) begin
                if (at_end) state_q <= TX_IDLE;
                else        pos_q   <= pos_q + wcnt_t'(1);
            end
            if (drop)           ovf_q <= 1'b1;
            else if (ovf_clr_i) ovf_q <= 1'b0;
        end
    end

    assign m_valid_o = (state_q == TX_SEND);
    assign m_data_o  = hold_q[pos_q];
    assign m_first_o = m_valid_o && (pos_q == '0);
    assign ovf_o     = ovf_q;

    // R1: reset clears the stream and the flag
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!m_valid_o && !ovf_o));

    // R4: a burst length stays within one to five words
    a_r4_len_range: assert property (@(posedge clk) disable iff (rst)
        m_valid_o |-> (len_q >= wcnt_t'(1) && len_q <= wcnt_t'(MAX_WORDS)));

    // R8: after a non-final word is taken, the marker is low
    a_r8_first_once: assert property (@(posedge clk) disable iff (rst)
        (fire && !at_end) |=> (m_valid_o && !m_first_o));

    // R9: a stalled word holds still
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (m_valid_o && !m_ready_i) |=>
            (m_valid_o && $stable(m_data_o) && $stable(m_first_o)));

    // R10: a strobe with no room raises the flag
    a_r10_drop_flags: assert property (@(posedge clk) disable iff (rst)
        drop |=> ovf_o);

    // R11: the flag only falls on a clear
    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && !ovf_clr_i) |=> ovf_o);

    // R12: a strobe on the final handshake starts a fresh burst
    a_r12_chain: assert property (@(posedge clk) disable iff (rst)
        (load_i && fire && at_end) |=> (m_first_o && !$rose(ovf_o)));
endmodule

// File: rtl/sample_packer.sv
module sample_packer
    import sp_pkg::*;
#(
    parameter int NUM_DIG = 32,
    parameter int NUM_ANA = 20,
    parameter int TS_IN_W = 32,
    localparam int IDX_W  = $clog2(NUM_DIG)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sample_i,
    input  logic [TS_IN_W-1:0]        ts_i,
    input  logic [NUM_DIG-1:0]        dig_i,
    input  logic [NUM_ANA*LANE_W-1:0] ana_i,
    input  logic [NUM_ANA-1:0]        cfg_ana_mask_i,
    input  logic [DSEL_N*IDX_W-1:0]   cfg_dig_idx_i,
    input  logic                      ovf_clr_i,
    input  logic                      m_ready_i,
    output logic                      m_valid_o,
    output logic [WORD_W-1:0]         m_data_o,
    output logic                      m_first_o,
    output logic                      ovf_o
);
    logic [DSEL_N-1:0]           dig_sel;
    logic [MAX_ACH*LANE_W-1:0]   lanes;
    wcnt_t                       nwords;
    head_t                       head;
    logic [MAX_WORDS*WORD_W-1:0] words;

    sp_dig_select #(.NUM_DIG(NUM_DIG)) u_dig (
        .dig_i  (dig_i),
        .idx_i  (cfg_dig_idx_i),
        .bits_o (dig_sel)
    );

    sp_ana_compact #(.NUM_ANA(NUM_ANA)) u_ana (
        .ana_i    (ana_i),
        .mask_i   (cfg_ana_mask_i),
        .lanes_o  (lanes),
        .nwords_o (nwords)
    );

    assign head.pad = '0;
    assign head.dig = dig_sel;
    assign head.ts  = ts_i[TS_W-1:0];

    assign words[0 +: WORD_W] = head;
    for (genvar w = 1; w < MAX_WORDS; w++) begin : g_word
        assign words[w*WORD_W +: WORD_W] = lanes[(w-1)*WORD_W +: WORD_W];
    end

    sp_burst_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .load_i    (sample_i),
        .words_i   (words),
        .nwords_i  (nwords),
        .ovf_clr_i (ovf_clr_i),
        .m_ready_i (m_ready_i),
        .m_valid_o (m_valid_o),
        .m_data_o  (m_data_o),
        .m_first_o (m_first_o),
        .ovf_o     (ovf_o)
    );
endmodule

// File: tb/tb_sample_packer.sv
`timescale 1ns/1ps
module tb_sample_packer;
    localparam int ND = 32, NA = 20, IW = 5;

    logic              clk = 0, rst = 1, sample_i = 0, ovf_clr_i = 0, m_ready_i = 0;
    logic [31:0]       ts_i = 0, dig_i = 0;
    logic [NA*16-1:0]  ana_i = '0;
    logic [NA-1:0]     cfg_ana_mask_i = '0;
    logic [19*IW-1:0]  cfg_dig_idx_i = '0;
    logic              m_valid_o, m_first_o, ovf_o;
    logic [63:0]       m_data_o;

    sample_packer dut (.*);

    always #5 clk = ~clk;

    int tests = 0, fails = 0;
    logic [31:0] rng = 32'h1234_5678;
    logic [63:0] exp_w [5];
    int          exp_n;

    function automatic logic [31:0] step(input logic [31:0] x);
        logic [31:0] y = x;
        y ^= y << 13; y ^= y >> 17; y ^= y << 5;
        return y;
    endfunction

    task automatic rnd(output logic [31:0] v);
        rng = step(rng); v = rng;
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic randomize_inputs(input logic [NA-1:0] mask);
        logic [31:0] r;
        rnd(r); ts_i = r;
        rnd(r); dig_i = r;
        for (int i = 0; i < NA; i++) begin rnd(r); ana_i[i*16 +: 16] = r[15:0]; end
        for (int k = 0; k < 19; k++) begin rnd(r); cfg_dig_idx_i[k*IW +: IW] = r[IW-1:0]; end
        cfg_ana_mask_i = mask;
    endtask

    task automatic compute_expected();
        int c = 0;
        for (int w = 0; w < 5; w++) exp_w[w] = '0;
        exp_w[0][23:0] = ts_i[23:0];
        for (int k = 0; k < 19; k++) exp_w[0][24+k] = dig_i[cfg_dig_idx_i[k*IW +: IW]];
        for (int i = 0; i < NA; i++)
            if (cfg_ana_mask_i[i] && c < 16) begin
                exp_w[1 + c/4][(c%4)*16 +: 16] = ana_i[i*16 +: 16];
                c++;
            end
        exp_n = 1 + (c + 3) / 4;
    endtask

    // Caller stands at a negedge; the strobe is seen at the next posedge.
    task automatic arm(input logic [NA-1:0] mask);
        randomize_inputs(mask);
        compute_expected();
        sample_i = 1;
    endtask

    task automatic release_and_scramble();
        logic [31:0] r;
        sample_i = 0;
        rnd(r); randomize_inputs(r[NA-1:0]);   // R7: later input changes must not matter
    endtask

    task automatic drain(input bit stall, input bit chain, input logic [NA-1:0] nmask);
        for (int w = 0; w < exp_n; w++) begin
            if (stall) begin
                m_ready_i = 0;
                @(negedge clk);
                chk(m_valid_o && m_data_o == exp_w[w], "R9 stalled word held", m_data_o, exp_w[w]);
            end
            m_ready_i = 1;
            chk(m_valid_o === 1'b1, "R4 word present", {63'b0, m_valid_o}, 64'd1);
            chk(m_data_o === exp_w[w], (w == 0) ? "R2/R3 head word" : "R5/R7 analogue word",
                m_data_o, exp_w[w]);
            chk(m_first_o === (w == 0), "R8 start marker", {63'b0, m_first_o}, {63'b0, w == 0});
            if (chain && w == exp_n - 1) begin
                arm(nmask);
                @(negedge clk);
                release_and_scramble();
                chk(m_first_o === 1'b1 && ovf_o === 1'b0, "R12 back-to-back start",
                    {62'b0, m_first_o, ovf_o}, 64'd2);
                return;
            end
            @(negedge clk);
        end
        chk(m_valid_o === 1'b0, "R4 burst length ends", {63'b0, m_valid_o}, 64'd0);
    endtask

    task automatic one_sample(input logic [NA-1:0] mask, input bit stall);
        arm(mask);
        @(negedge clk);
        release_and_scramble();
        drain(stall, 1'b0, '0);
    endtask

    bit done = 0;

    initial begin
        logic [31:0] r;
        @(negedge clk);
        chk(m_valid_o === 1'b0 && ovf_o === 1'b0, "R1 reset state", {62'b0, m_valid_o, ovf_o}, 0);
        @(negedge clk);
        rst = 0;
        chk(m_valid_o === 1'b0 && ovf_o === 1'b0, "R1 after reset", {62'b0, m_valid_o, ovf_o}, 0);

        one_sample('0, 0);                                    // R4 head only
        for (int i = 0; i < NA; i++) one_sample(NA'(1) << i, i % 2);  // R5 each lane
        one_sample('1, 0);                                    // R6 twenty enabled, sixteen sent
        one_sample('1, 1);
        for (int t = 0; t < 200; t++) begin
            rnd(r);
            one_sample(r[NA-1:0] & (t[0] ? r[31:12] : '1), t[1]);
        end

        // R12 chain: strobe on final handshake
        arm(20'h000F0);
        @(negedge clk);
        release_and_scramble();
        drain(0, 1, 20'h00007);
        drain(0, 1, 20'h00000);
        drain(0, 0, '0);

        // R10 drop while stalled
        arm(20'h00033);
        @(negedge clk);
        release_and_scramble();
        m_ready_i = 0;
        @(negedge clk);
        sample_i = 1;
        @(negedge clk);
        sample_i = 0;
        chk(ovf_o === 1'b1, "R10 drop sets flag", {63'b0, ovf_o}, 1);
        drain(0, 0, '0);                                      // R10 no extra burst
        repeat (3) @(negedge clk);
        chk(m_valid_o === 1'b0, "R10 dropped sample silent", {63'b0, m_valid_o}, 0);
        chk(ovf_o === 1'b1, "R11 flag sticky", {63'b0, ovf_o}, 1);
        ovf_clr_i = 1;
        @(negedge clk);
        ovf_clr_i = 0;
        chk(ovf_o === 1'b0, "R11 clear", {63'b0, ovf_o}, 0);

        // R11 drop and clear together: set wins
        arm(20'h00001);
        @(negedge clk);
        release_and_scramble();
        m_ready_i = 0;
        @(negedge clk);
        sample_i = 1; ovf_clr_i = 1;
        @(negedge clk);
        sample_i = 0; ovf_clr_i = 0;
        chk(ovf_o === 1'b1, "R11 set wins over clear", {63'b0, ovf_o}, 1);
        drain(0, 0, '0);
        ovf_clr_i = 1;
        @(negedge clk);
        ovf_clr_i = 0;
        chk(ovf_o === 1'b0, "R11 clear again", {63'b0, ovf_o}, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule